// File: doc/BRIEF.md
# Prescaled Down-Counter with Input Capture

This block is one 32-bit timer channel. A down-counter decrements once per tick of a selectable count clock. The count clock is one of five power-of-four divisions of the peripheral clock, a one-cycle tick pulse from an on-chip real-time-clock, or rising edges of an external clock pin. When the counter passes through zero it reloads from a constant register and raises an underflow flag.

A capture input, sampled through a two-flop synchronizer, can freeze the live counter value into a read-only capture register on a chosen edge. The first capture after the flag was cleared is held until software clears the flag again, so later edges cannot overwrite it. One interrupt line combines the two flags with their enables.

Software reaches four word registers through a single-cycle write strobe and a combinational read port. Address 0 holds control, address 1 holds the reload constant, address 2 holds the counter and address 3 holds the capture register. The control word packs the fields from bit 0 upward: clock select [2:0], capture edge [4:3], capture enable [5], capture interrupt enable [6], underflow interrupt enable [7], start [8], underflow flag [9] and capture flag [10]. Bits 31:11 read as 0.

Top module: `ptimer_cap`

## Requirements
- R1: Clock select codes 0 to 4 give one decrement per 4, 16, 64, 256 and 1024 peripheral clocks. The divider restarts whenever start is 0, so the first decrement comes exactly one full period after start is set.
- R2: Clock select code 5 is reserved: with start set, the counter holds its value.
- R3: Clock select code 6 gives one decrement for each clock cycle in which the real-time-clock tick input is high.
- R4: Clock select code 7 gives one decrement per rising edge of the external clock pin, after two-flop synchronization.
- R5: A tick while the counter is 0 reloads the counter from the constant register and sets the underflow flag (bit 9).
- R6: The counter changes only while start (bit 8) is 1. A counter write while stopped loads the written value. A counter write while running is ignored.
- R7: With capture enable (bit 5) set, a synchronized capture-input edge of the selected kind (edge field 0 = rising, 1 = falling, 2 or 3 = both) copies the counter into the capture register and sets the capture flag (bit 10).
- R8: While the capture flag is 1, further capture edges leave the capture register unchanged.
- R9: A control write of 0 to a flag bit clears it, and a write of 1 keeps its previous value. A flag-setting event in the same cycle as a clearing write leaves the flag at 1.
- R10: irq is high exactly while (underflow flag and bit 7) or (capture flag and bit 6).
- R11: After reset, all four registers read 0 and irq is 0.
- R12: Writes to the capture register address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 constant, 2 counter, 3 capture) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| rtc_tick | input | 1 | Real-time-clock tick, one cycle per tick |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_in | input | 1 | Capture input, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag being set in the very cycle that software writes 0 to clear it. The bench reaches it by parking the counter at 0 with the tick-pulse source selected. It then raises the tick pulse in the same cycle as the clearing control write, so the underflow and the clear meet on one edge. Capture holding is reached by clearing the flag only after a second qualified edge has arrived with a new counter value loaded. The prescaler divisions are checked by running an exact whole number of periods from the start write, so an off-by-one division changes the read-back count.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [2:0] {
        CS_DIV4    = 3'd0,
        CS_DIV16   = 3'd1,
        CS_DIV64   = 3'd2,
        CS_DIV256  = 3'd3,
        CS_DIV1024 = 3'd4,
        CS_RSVD    = 3'd5,
        CS_RTC     = 3'd6,
        CS_EXT     = 3'd7
    } clk_sel_e;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_CONST = 2'd1,
        RA_COUNT = 2'd2,
        RA_CAPT  = 2'd3
    } reg_addr_e;

    localparam logic [1:0] EDG_RISE = 2'd0;
    localparam logic [1:0] EDG_FALL = 2'd1;

    // control word, MSB first
    typedef struct packed {
        logic       cap_flag;
        logic       unf_flag;
        logic       run;
        logic       unf_ie;
        logic       cap_ie;
        logic       cap_en;
        logic [1:0] edge_sel;
        clk_sel_e   csel;
    } ctrl_t;

    localparam int unsigned CTRL_W  = $bits(ctrl_t);
    localparam int unsigned NUM_DIV = 5;
    localparam int unsigned SEL_N   = 8;

    // log2 of the division ratio for prescaler tap idx
    function automatic int unsigned div_log2(input int unsigned idx);
        return 2 + 2 * idx;
    endfunction

    function automatic logic edge_match(input logic [1:0] mode,
                                        input logic rise,
                                        input logic fall);
        case (mode)
            EDG_RISE: return rise;
            EDG_FALL: return fall;
            default:  return rise | fall;
        endcase
    endfunction

endpackage

// File: rtl/ptc_sync_edge.sv
module ptc_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic [1:0] mode,
    output logic       hit
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    logic rise, fall;
    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
    assign hit  = ptc_pkg::edge_match(mode, rise, fall);
endmodule

// File: rtl/ptc_tick_sel.sv
module ptc_tick_sel
    import ptc_pkg::*;
#(
    parameter int unsigned N_DIV = NUM_DIV
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_sel_e csel,
    input  logic     rtc_tick,
    input  logic     ext_hit,
    output logic     tick
);
    localparam int unsigned PRE_W = div_log2(N_DIV - 1);

    logic [PRE_W-1:0] pre;
    logic [N_DIV-1:0] div_tick;
    logic [SEL_N-1:0] div_pad;

    // prescaler restarts while stopped
    always_ff @(posedge clk) begin
        if (rst || !run) pre <= '0;
        else             pre <= pre + 1'b1;
    end

    for (genvar i = 0; i < N_DIV; i++) begin : g_tap
        localparam int unsigned L = div_log2(i);
        assign div_tick[i] = &pre[L-1:0];
    end

    assign div_pad = {{(SEL_N - N_DIV){1'b0}}, div_tick};

    always_comb begin
        case (csel)
            CS_RSVD: tick = 1'b0;
            CS_RTC:  tick = rtc_tick;
            CS_EXT:  tick = ext_hit;
            default: tick = div_pad[csel];
        endcase
    end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         underflow
);
    logic at_zero;
    assign at_zero   = (cnt == '0);
    assign underflow = run & tick & at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run) begin
            if (load) cnt <= load_val;
        end else if (tick) begin
            cnt <= at_zero ? reload_val : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ptc_capture.sv
module ptc_capture #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         hit,
    input  logic         flag,
    input  logic [W-1:0] cnt,
    output logic         evt,
    output logic [W-1:0] cap_q
);
    assign evt = en & hit;

    always_ff @(posedge clk) begin
        if (rst)              cap_q <= '0;
        else if (evt && !flag) cap_q <= cnt;
    end
endmodule

// File: rtl/ptimer_cap.sv
module ptimer_cap
    import ptc_pkg::*;
#(
    parameter int unsigned W           = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         rtc_tick,
    input  logic         ext_clk,
    input  logic         cap_in,
    output logic         irq
);
    ctrl_t        ctrl_q, ctrl_wr;
    logic [W-1:0] const_q, cnt, cap_q;
    logic         wr_ctrl, wr_const, wr_cnt;
    logic         ext_hit, cap_hit, tick, underflow, cap_evt;
    logic         unf_next, cap_next;

    assign wr_ctrl  = wr_en && (reg_addr_e'(addr) == RA_CTRL);
    assign wr_const = wr_en && (reg_addr_e'(addr) == RA_CONST);
    assign wr_cnt   = wr_en && (reg_addr_e'(addr) == RA_COUNT);
    assign ctrl_wr  = ctrl_t'(wdata[CTRL_W-1:0]);

    ptc_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst(rst), .din(ext_clk), .mode(EDG_RISE), .hit(ext_hit)
    );

    ptc_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst(rst), .din(cap_in), .mode(ctrl_q.edge_sel), .hit(cap_hit)
    );

    ptc_tick_sel u_tick (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .csel(ctrl_q.csel),
        .rtc_tick(rtc_tick), .ext_hit(ext_hit), .tick(tick)
    );

    ptc_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick),
        .load(wr_cnt), .load_val(wdata), .reload_val(const_q),
        .cnt(cnt), .underflow(underflow)
    );

    ptc_capture #(.W(W)) u_cap (
        .clk(clk), .rst(rst), .en(ctrl_q.cap_en), .hit(cap_hit),
        .flag(ctrl_q.cap_flag), .cnt(cnt), .evt(cap_evt), .cap_q(cap_q)
    );

    // flags: writing 0 clears, writing 1 keeps, a set event wins
    assign unf_next = (ctrl_q.unf_flag & ~(wr_ctrl & ~ctrl_wr.unf_flag)) | underflow;
    assign cap_next = (ctrl_q.cap_flag & ~(wr_ctrl & ~ctrl_wr.cap_flag)) | cap_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            const_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.csel     <= ctrl_wr.csel;
                ctrl_q.edge_sel <= ctrl_wr.edge_sel;
                ctrl_q.cap_en   <= ctrl_wr.cap_en;
                ctrl_q.cap_ie   <= ctrl_wr.cap_ie;
                ctrl_q.unf_ie   <= ctrl_wr.unf_ie;
                ctrl_q.run      <= ctrl_wr.run;
            end
            ctrl_q.unf_flag <= unf_next;
            ctrl_q.cap_flag <= cap_next;
            if (wr_const) const_q <= wdata;
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_CTRL:  rdata = {{(W - CTRL_W){1'b0}}, ctrl_q};
            RA_CONST: rdata = const_q;
            RA_COUNT: rdata = cnt;
            default:  rdata = cap_q;
        endcase
    end

    assign irq = (ctrl_q.unf_flag & ctrl_q.unf_ie) | (ctrl_q.cap_flag & ctrl_q.cap_ie);
endmodule

// File: rtl/ptimer_cap_chk.sv
module ptimer_cap_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_wr,
    input logic         run,
    input logic [2:0]   csel,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] const_q,
    input logic         unf_flag,
    input logic         cap_evt,
    input logic         cap_flag,
    input logic [W-1:0] cap_q
);
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && csel == 3'd5) |=> $stable(cnt)); // R2

    AST_UNF_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (run && tick && cnt == '0) |=> (cnt == $past(const_q) && unf_flag)); // R5

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt)); // R6

    AST_RUN_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_wr && !tick) |=> $stable(cnt)); // R6

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && !cap_flag) |=> (cap_flag && cap_q == $past(cnt))); // R7

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        cap_flag |=> $stable(cap_q)); // R8
endmodule

bind ptimer_cap ptimer_cap_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .cnt_wr(wr_cnt), .run(ctrl_q.run),
    .csel(ctrl_q.csel), .tick(tick), .cnt(cnt), .const_q(const_q),
    .unf_flag(ctrl_q.unf_flag), .cap_evt(cap_evt),
    .cap_flag(ctrl_q.cap_flag), .cap_q(cap_q)
);

// File: tb/ptimer_cap_tb.sv
`timescale 1ns/1ps
module ptimer_cap_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rtc_tick = 1'b0;
    logic        ext_clk = 1'b0;
    logic        cap_in = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ptimer_cap u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rtc_tick(rtc_tick), .ext_clk(ext_clk),
        .cap_in(cap_in), .irq(irq)
    );

    // csel, wait cycles after start, expected count from 100
    localparam logic [50:0] VECS [6] = '{
        {3'd0, 16'd8,    32'd98},
        {3'd1, 16'd32,   32'd98},
        {3'd2, 16'd128,  32'd98},
        {3'd3, 16'd512,  32'd98},
        {3'd4, 16'd2048, 32'd98},
        {3'd5, 16'd200,  32'd100}
    };

    function automatic logic [31:0] ctl(input logic [2:0] cs, input logic [1:0] edg,
                                        input logic cen, input logic cie,
                                        input logic uie, input logic run,
                                        input logic uf, input logic cf);
        return {21'b0, cf, uf, run, uie, cie, cen, edg, cs};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst = 1'b0;

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R11 reset reg", v, 32'd0);
        end
        chk("R11 reset irq", {31'b0, irq}, 32'd0);

        // R1 / R2 table of clock selects
        for (int i = 0; i < 6; i++) begin
            logic [2:0]  cs;
            logic [15:0] w;
            logic [31:0] e;
            {cs, w, e} = VECS[i];
            wr(2'd0, ctl(cs, 2'd0, 0, 0, 0, 0, 0, 0));
            wr(2'd2, 32'd100);
            wr(2'd0, ctl(cs, 2'd0, 0, 0, 0, 1, 0, 0));
            idle(int'(w) - 1);
            wr(2'd0, ctl(cs, 2'd0, 0, 0, 0, 0, 0, 0));
            rd(2'd2, v);
            chk((cs == 3'd5) ? "R2 reserved hold" : "R1 prescale", v, e);
        end

        // R6 counter write while running is ignored
        wr(2'd2, 32'd77);
        wr(2'd0, ctl(3'd5, 2'd0, 0, 0, 0, 1, 0, 0));
        wr(2'd2, 32'd5);
        rd(2'd2, v);
        chk("R6 running write ignored", v, 32'd77);
        wr(2'd0, ctl(3'd5, 2'd0, 0, 0, 0, 0, 0, 0));
        idle(5);
        rd(2'd2, v);
        chk("R6 stopped hold", v, 32'd77);

        // R5 underflow reload, R10 irq, R9 write-1 keeps
        wr(2'd2, 32'd1);
        wr(2'd1, 32'd9);
        wr(2'd0, ctl(3'd0, 2'd0, 0, 0, 1, 1, 0, 0));
        idle(11);
        wr(2'd0, ctl(3'd0, 2'd0, 0, 0, 1, 0, 1, 0));
        rd(2'd2, v);
        chk("R5 reload value", v, 32'd8);
        rd(2'd0, v);
        chk("R9 write one keeps unf flag", {31'b0, v[9]}, 32'd1);
        chk("R10 irq on underflow", {31'b0, irq}, 32'd1);
        wr(2'd0, ctl(3'd0, 2'd0, 0, 0, 1, 0, 0, 0));
        rd(2'd0, v);
        chk("R9 write zero clears", {31'b0, v[9]}, 32'd0);
        chk("R10 irq drops", {31'b0, irq}, 32'd0);

        // R9 set beats clear, with RTC tick source (R3)
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd5);
        wr(2'd0, ctl(3'd6, 2'd0, 0, 0, 0, 1, 0, 0));
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wdata = ctl(3'd6, 2'd0, 0, 0, 0, 1, 0, 0);
        rtc_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rtc_tick = 1'b0;
        rd(2'd0, v);
        chk("R9 set wins over clear", {31'b0, v[9]}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); rtc_tick = 1'b1;
            @(negedge clk); rtc_tick = 1'b0;
            idle(2);
        end
        wr(2'd0, ctl(3'd6, 2'd0, 0, 0, 0, 0, 0, 0));
        rd(2'd2, v);
        chk("R3 rtc ticks", v, 32'd2);

        // R4 external clock
        wr(2'd2, 32'd50);
        wr(2'd0, ctl(3'd7, 2'd0, 0, 0, 0, 1, 0, 0));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
        idle(5);
        wr(2'd0, ctl(3'd7, 2'd0, 0, 0, 0, 0, 0, 0));
        rd(2'd2, v);
        chk("R4 external edges", v, 32'd46);

        // R7 / R8 / R12 capture
        wr(2'd2, 32'h1234);
        wr(2'd0, ctl(3'd5, 2'd0, 1, 1, 0, 0, 0, 0));
        @(negedge clk); cap_in = 1'b1;
        idle(4);
        rd(2'd3, v);
        chk("R7 rising capture", v, 32'h1234);
        rd(2'd0, v);
        chk("R7 capture flag", {31'b0, v[10]}, 32'd1);
        chk("R10 irq on capture", {31'b0, irq}, 32'd1);
        wr(2'd2, 32'h5678);
        @(negedge clk); cap_in = 1'b0; idle(4);
        cap_in = 1'b1; idle(4);
        rd(2'd3, v);
        chk("R8 capture held", v, 32'h1234);
        wr(2'd3, 32'hdead);
        rd(2'd3, v);
        chk("R12 capture read only", v, 32'h1234);
        wr(2'd0, ctl(3'd5, 2'd1, 1, 1, 0, 0, 0, 0));
        chk("R10 irq after clear", {31'b0, irq}, 32'd0);
        @(negedge clk); cap_in = 1'b0;
        idle(4);
        rd(2'd3, v);
        chk("R7 falling capture", v, 32'h5678);

        // R7 capture disabled
        wr(2'd0, ctl(3'd5, 2'd2, 0, 0, 0, 0, 0, 0));
        wr(2'd2, 32'h9);
        @(negedge clk); cap_in = 1'b1;
        idle(4);
        rd(2'd3, v);
        chk("R7 disabled no capture", v, 32'h5678);
        rd(2'd0, v);
        chk("R7 disabled no flag", {31'b0, v[10]}, 32'd0);

        // R7 both edges
        wr(2'd0, ctl(3'd5, 2'd2, 1, 0, 0, 0, 0, 0));
        wr(2'd2, 32'hab);
        @(negedge clk); cap_in = 1'b0;
        idle(4);
        rd(2'd3, v);
        chk("R7 both edges", v, 32'hab);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule